// File: doc/BRIEF.md
# Reset Cause and Wake-up Recorder

This block sits beside a small processor core and remembers why the core last restarted or woke up. Each restart or wake source delivers a one-cycle pulse. The sources are power-on, brown-out, a reset instruction, a configuration mismatch, the external reset pin, a watchdog time-out, a wake-up interrupt, stack overflow and stack underflow. The block also watches the current power mode and an enable that lets stack overflow and underflow force a reset.

The block holds six sticky cause flags and two stack error flags. Software reads all eight through `cause_flags` and can overwrite them through a write port. Each event changes its own subset of flags. The power mode at the time of the event decides the flag values. It also decides whether the core restarts at the reset vector or resumes at PC+2. The block answers with a one-cycle restart request and a 2-bit program-counter select.

When several events arrive in the same cycle, only the one with the highest priority takes effect.

Top module: `rcr_recorder`

## Requirements
- R1: A power-on pulse sets flag bits 5 (mismatch), 4 (reset instruction), 3 (time-out) and 2 (power-down) to 1. It clears bit 0 (power-on), bit 1 (brown-out) and bit 6 (stack full), leaves bit 7 unchanged, and restarts with select 0 (address 0000h).
- R2: A brown-out pulse sets bits 5, 4, 3 and 2, clears bit 1, leaves bits 0, 6 and 7 unchanged, and restarts with select 0.
- R3: A configuration-mismatch pulse clears only bit 5, and a reset-instruction pulse clears only bit 4. Both restart with select 0.
- R4: An external-pin reset restarts with select 0 in every mode. `pwr_mode` is 0 for full power, 1 for managed run, 2 for idle and 3 for sleep. The pin changes no flag in full power, sets bit 3 in managed run, and sets bit 3 and clears bit 2 in idle or sleep.
- R5: A watchdog time-out in full power or managed run clears bit 3 and restarts with select 0.
- R6: A watchdog time-out in idle or sleep clears bits 3 and 2 and resumes with select 1 (PC+2).
- R7: A wake-up interrupt in any mode other than full power clears bit 2. It issues a restart with select 2 (0008h) if `irq_en_hi` is 1, otherwise select 3 (0018h) if `irq_en_lo` is 1, otherwise select 1. In full power it has no effect on flags or outputs.
- R8: Stack overflow sets bit 6 and stack underflow sets bit 7. Either one restarts with select 0 only when `stk_ovf_rst_en` is 1; with the enable at 0 no restart is issued.
- R9: When several events arrive together, only the highest-priority one acts. The order, highest first, is: power-on, brown-out, pin, watchdog, overflow, underflow, mismatch, reset instruction, wake-up.
- R10: With no event pulse active, `sw_wr_en` loads `sw_wr_data` into the flags. A write in the same cycle as any event pulse is ignored. With neither a write nor an event, the flags hold and no restart is issued.
- R11: Every result appears on the clock edge that samples the event. The restart request lasts one cycle per event. `pc_sel` reads 0 whenever `restart_req` is 0. Reset (`rst_n` low at a clock edge) leaves flags 0x3C with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_por | input | 1 | Power-on event pulse |
| ev_bor | input | 1 | Brown-out event pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_wdt | input | 1 | Watchdog time-out pulse |
| ev_stk_ovf | input | 1 | Stack overflow pulse |
| ev_stk_unf | input | 1 | Stack underflow pulse |
| ev_cfg_mism | input | 1 | Configuration mismatch pulse |
| ev_rst_instr | input | 1 | Reset instruction pulse |
| ev_wake_irq | input | 1 | Wake-up interrupt pulse |
| pwr_mode | input | 2 | 0 full power, 1 managed run, 2 idle, 3 sleep |
| stk_ovf_rst_en | input | 1 | Stack errors force a reset when 1 |
| irq_en_hi | input | 1 | High-priority global interrupt enable |
| irq_en_lo | input | 1 | Low-priority global interrupt enable |
| sw_wr_en | input | 1 | Software flag write strobe |
| sw_wr_data | input | 8 | Software flag write value |
| cause_flags | output | 8 | Flag register (bit map in R1-R8 text) |
| restart_req | output | 1 | One-cycle restart or resume request |
| pc_sel | output | 2 | 0: 0000h, 1: PC+2, 2: 0008h, 3: 0018h |

## Verification
Every result is registered once, so flags, `restart_req` and `pc_sel` are due exactly one clock edge after an event or write is presented. The bench drives stimulus on the falling edge and samples on the next falling edge, half a cycle after the edge that captured it. One cycle later, with the inputs idle, it confirms that the restart pulse has ended and the flags held. The sweep covers every combination of the nine event inputs across all four modes and all enable settings. Each case starts from a known flag pattern loaded through the write port, with a conflicting write held high during the event.

// File: rtl/rcr_pkg.sv
// Package: shared types and constants of the reset cause recorder.
// Assumes flag positions are fixed because software decodes them.
package rcr_pkg;
    localparam int NUM_EVENTS = 9;
    localparam int NUM_FLAGS  = 8;
    localparam int SEL_W      = 2;

    // Flag bit positions seen by software
    localparam int FB_POR  = 0;
    localparam int FB_BOR  = 1;
    localparam int FB_PD   = 2;
    localparam int FB_TO   = 3;
    localparam int FB_RI   = 4;
    localparam int FB_CM   = 5;
    localparam int FB_SFUL = 6;
    localparam int FB_SUNF = 7;

    localparam logic [NUM_FLAGS-1:0] FLAGS_RST = 8'h3C;

    // Winning event; order after EV_NONE matches priority (R9)
    typedef enum logic [3:0] {
        EV_NONE, EV_POR, EV_BOR, EV_PIN, EV_WDT,
        EV_OVF, EV_UNF, EV_MISM, EV_RINST, EV_WAKE
    } ev_kind_t;

    typedef enum logic [1:0] {PM_FULL, PM_RUN, PM_IDLE, PM_SLEEP} pmode_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RESET = 2'd0, SEL_NEXT = 2'd1, SEL_HIGH = 2'd2, SEL_LOW = 2'd3
    } pc_sel_t;
endpackage

// File: rtl/rcr_priority_pick.sv
// Fixed-priority picker: returns the lowest set index of req.
// Assumes index 0 carries the highest priority.
module rcr_priority_pick #(
    parameter int N = 9,
    localparam int IW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from low priority up so the highest priority set bit wins
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rcr_flag_next.sv
// Next-state logic: applies the winning event, or a software write,
// to the current flags and chooses restart and program-counter select.
// Assumes kind is EV_NONE when no event pulse is active.
module rcr_flag_next
    import rcr_pkg::*;
(
    input  ev_kind_t             kind,
    input  pmode_t               mode,
    input  logic                 stk_rst_en,
    input  logic                 gie_hi,
    input  logic                 gie_lo,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_data,
    input  logic [NUM_FLAGS-1:0] cur,
    output logic [NUM_FLAGS-1:0] nxt,
    output logic                 do_restart,
    output pc_sel_t              sel
);
    logic low_power;
    assign low_power = (mode == PM_IDLE) || (mode == PM_SLEEP);

    // Per-event flag update and restart decision
    always_comb begin
        nxt        = cur;
        do_restart = 1'b0;
        sel        = SEL_RESET;
        case (kind)
            EV_NONE: begin
                if (wr_en) nxt = wr_data;
            end
            EV_POR: begin
                nxt[FB_CM]   = 1'b1;
                nxt[FB_RI]   = 1'b1;
                nxt[FB_TO]   = 1'b1;
                nxt[FB_PD]   = 1'b1;
                nxt[FB_POR]  = 1'b0;
                nxt[FB_BOR]  = 1'b0;
                nxt[FB_SFUL] = 1'b0;
                do_restart   = 1'b1;
            end
            EV_BOR: begin
                nxt[FB_CM]  = 1'b1;
                nxt[FB_RI]  = 1'b1;
                nxt[FB_TO]  = 1'b1;
                nxt[FB_PD]  = 1'b1;
                nxt[FB_BOR] = 1'b0;
                do_restart  = 1'b1;
            end
            EV_PIN: begin
                if (mode != PM_FULL) nxt[FB_TO] = 1'b1;
                if (low_power)       nxt[FB_PD] = 1'b0;
                do_restart = 1'b1;
            end
            EV_WDT: begin
                nxt[FB_TO] = 1'b0;
                if (low_power) begin
                    nxt[FB_PD] = 1'b0;
                    sel        = SEL_NEXT;
                end
                do_restart = 1'b1;
            end
            EV_OVF: begin
                nxt[FB_SFUL] = 1'b1;
                do_restart   = stk_rst_en;
            end
            EV_UNF: begin
                nxt[FB_SUNF] = 1'b1;
                do_restart   = stk_rst_en;
            end
            EV_MISM: begin
                nxt[FB_CM] = 1'b0;
                do_restart = 1'b1;
            end
            EV_RINST: begin
                nxt[FB_RI] = 1'b0;
                do_restart = 1'b1;
            end
            EV_WAKE: begin
                if (mode != PM_FULL) begin
                    nxt[FB_PD] = 1'b0;
                    do_restart = 1'b1;
                    if (gie_hi)      sel = SEL_HIGH;
                    else if (gie_lo) sel = SEL_LOW;
                    else             sel = SEL_NEXT;
                end
            end
            default: begin
                nxt = cur;
            end
        endcase
    end
endmodule

// File: rtl/rcr_recorder.sv
// Top: reset cause and wake-up recorder. Ranks the event pulses,
// updates the eight flags and issues a one-cycle restart request
// with a program-counter select. Assumes event pulses are synchronous
// to clk and last one cycle each.
module rcr_recorder
    import rcr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_por,
    input  logic                 ev_bor,
    input  logic                 ev_pin,
    input  logic                 ev_wdt,
    input  logic                 ev_stk_ovf,
    input  logic                 ev_stk_unf,
    input  logic                 ev_cfg_mism,
    input  logic                 ev_rst_instr,
    input  logic                 ev_wake_irq,
    input  logic [1:0]           pwr_mode,
    input  logic                 stk_ovf_rst_en,
    input  logic                 irq_en_hi,
    input  logic                 irq_en_lo,
    input  logic                 sw_wr_en,
    input  logic [NUM_FLAGS-1:0] sw_wr_data,
    output logic [NUM_FLAGS-1:0] cause_flags,
    output logic                 restart_req,
    output logic [SEL_W-1:0]     pc_sel
);
    localparam int IW = $clog2(NUM_EVENTS + 1);

    logic [NUM_EVENTS-1:0] req;
    logic                  hit;
    logic [IW-1:0]         idx;
    ev_kind_t              kind;
    logic [NUM_FLAGS-1:0]  flags_q, flags_d;
    logic                  rst_d;
    pc_sel_t               sel_d;

    // Pack the pulses in priority order, index 0 highest
    assign req = {ev_wake_irq, ev_rst_instr, ev_cfg_mism, ev_stk_unf,
                  ev_stk_ovf, ev_wdt, ev_pin, ev_bor, ev_por};

    rcr_priority_pick #(.N(NUM_EVENTS)) i_pick (
        .req (req),
        .hit (hit),
        .idx (idx)
    );

    // Turn the picked index into an event kind
    always_comb begin
        if (hit) kind = ev_kind_t'(4'(idx) + 4'd1);
        else     kind = EV_NONE;
    end

    rcr_flag_next i_next (
        .kind       (kind),
        .mode       (pmode_t'(pwr_mode)),
        .stk_rst_en (stk_ovf_rst_en),
        .gie_hi     (irq_en_hi),
        .gie_lo     (irq_en_lo),
        .wr_en      (sw_wr_en),
        .wr_data    (sw_wr_data),
        .cur        (flags_q),
        .nxt        (flags_d),
        .do_restart (rst_d),
        .sel        (sel_d)
    );

    // Register flags, restart pulse and select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q     <= FLAGS_RST;
            restart_req <= 1'b0;
            pc_sel      <= SEL_RESET;
        end else begin
            flags_q     <= flags_d;
            restart_req <= rst_d;
            pc_sel      <= rst_d ? sel_d : SEL_RESET;
        end
    end

    assign cause_flags = flags_q;
endmodule

// File: rtl/rcr_checker.sv
// Checker: protocol properties of the recorder, seen at its ports.
// Assumes the bind below attaches it to every rcr_recorder instance.
module rcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_por,
    input logic       ev_bor,
    input logic       ev_pin,
    input logic       ev_wdt,
    input logic       ev_stk_ovf,
    input logic       ev_stk_unf,
    input logic       ev_cfg_mism,
    input logic       ev_rst_instr,
    input logic       ev_wake_irq,
    input logic [1:0] pwr_mode,
    input logic       stk_ovf_rst_en,
    input logic       sw_wr_en,
    input logic [7:0] sw_wr_data,
    input logic [7:0] cause_flags,
    input logic       restart_req,
    input logic [1:0] pc_sel
);
    logic ev_any, wdt_top, unf_top;
    assign ev_any  = ev_por | ev_bor | ev_pin | ev_wdt | ev_stk_ovf |
                     ev_stk_unf | ev_cfg_mism | ev_rst_instr | ev_wake_irq;
    assign wdt_top = ev_wdt && !ev_por && !ev_bor && !ev_pin;
    assign unf_top = ev_stk_unf && !ev_stk_ovf && !wdt_top && !ev_wdt &&
                     !ev_por && !ev_bor && !ev_pin;

    p_por_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (cause_flags[5:2] == 4'hF) && (cause_flags[1:0] == 2'b00)
                   && !cause_flags[6] && restart_req && (pc_sel == 2'd0));

    p_wdt_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_top && pwr_mode[1] |=> restart_req && (pc_sel == 2'd1)
                                   && !cause_flags[3] && !cause_flags[2]);

    p_unf_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_top && !stk_ovf_rst_en |=> !restart_req && cause_flags[7]);

    p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && !ev_any |=> cause_flags == $past(sw_wr_data));

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_any && !sw_wr_en |=> $stable(cause_flags) && !restart_req);

    p_sel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_req |-> pc_sel == 2'd0);
endmodule

bind rcr_recorder rcr_checker i_rcr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_por         (ev_por),
    .ev_bor         (ev_bor),
    .ev_pin         (ev_pin),
    .ev_wdt         (ev_wdt),
    .ev_stk_ovf     (ev_stk_ovf),
    .ev_stk_unf     (ev_stk_unf),
    .ev_cfg_mism    (ev_cfg_mism),
    .ev_rst_instr   (ev_rst_instr),
    .ev_wake_irq    (ev_wake_irq),
    .pwr_mode       (pwr_mode),
    .stk_ovf_rst_en (stk_ovf_rst_en),
    .sw_wr_en       (sw_wr_en),
    .sw_wr_data     (sw_wr_data),
    .cause_flags    (cause_flags),
    .restart_req    (restart_req),
    .pc_sel         (pc_sel)
);

// File: tb/test_rcr_recorder.sv
// Bench: sweeps all event combinations, modes and enables and compares
// against a model built from the requirements.
module test_rcr_recorder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] ev = '0;   // 0 por,1 bor,2 pin,3 wdt,4 ovf,5 unf,6 mism,7 rinst,8 wake
    logic [1:0] mode = '0;
    logic       en = 1'b0, gh = 1'b0, gl = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] flags;
    logic       rreq;
    logic [1:0] sel;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rcr_recorder i_rcr_recorder (
        .clk(clk), .rst_n(rst_n),
        .ev_por(ev[0]), .ev_bor(ev[1]), .ev_pin(ev[2]), .ev_wdt(ev[3]),
        .ev_stk_ovf(ev[4]), .ev_stk_unf(ev[5]), .ev_cfg_mism(ev[6]),
        .ev_rst_instr(ev[7]), .ev_wake_irq(ev[8]),
        .pwr_mode(mode), .stk_ovf_rst_en(en), .irq_en_hi(gh), .irq_en_lo(gl),
        .sw_wr_en(wr), .sw_wr_data(wdata),
        .cause_flags(flags), .restart_req(rreq), .pc_sel(sel)
    );

    // Requirement model: returns {restart, select, flags}
    function automatic logic [10:0] model(input logic [8:0] m, input logic [1:0] md,
                                          input logic e, input logic h, input logic l,
                                          input logic [7:0] old, input logic [7:0] wd);
        logic [7:0] f = old;
        logic       r = 1'b0;
        logic [1:0] s = 2'd0;
        if (m == 9'd0) f = wd;                                        // R10
        else if (m[0]) begin f[5:2] = 4'hF; f[1:0] = 2'b00; f[6] = 1'b0; r = 1'b1; end // R1
        else if (m[1]) begin f[5:2] = 4'hF; f[1] = 1'b0; r = 1'b1; end // R2
        else if (m[2]) begin                                           // R4
            if (md != 2'd0) f[3] = 1'b1;
            if (md >= 2'd2) f[2] = 1'b0;
            r = 1'b1;
        end else if (m[3]) begin                                       // R5 R6
            f[3] = 1'b0; r = 1'b1;
            if (md >= 2'd2) begin f[2] = 1'b0; s = 2'd1; end
        end else if (m[4]) begin f[6] = 1'b1; r = e; end              // R8
        else if (m[5]) begin f[7] = 1'b1; r = e; end
        else if (m[6]) begin f[5] = 1'b0; r = 1'b1; end               // R3
        else if (m[7]) begin f[4] = 1'b0; r = 1'b1; end
        else if (md != 2'd0) begin                                     // R7
            f[2] = 1'b0; r = 1'b1;
            s = h ? 2'd2 : (l ? 2'd3 : 2'd1);
        end
        return {r, s, f};
    endfunction

    function automatic string tag_of(input logic [8:0] m, input logic [1:0] md);
        if ($countones(m) > 1) return "R9";
        if (m[0]) return "R1";
        if (m[1]) return "R2";
        if (m[2]) return "R4";
        if (m[3]) return (md >= 2'd2) ? "R6" : "R5";
        if (m[4] || m[5]) return "R8";
        if (m[6] || m[7]) return "R3";
        if (m[8]) return "R7";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "reset flags", int'(flags), 'h3C);
        check("R11", "reset restart", int'(rreq), 0);
        check("R11", "reset select", int'(sel), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 512; m++) begin
            for (int md = 0; md < 4; md++) begin
                for (int g = 0; g < 8; g++) begin
                    logic [7:0]  pat = 8'((m * 37) + (md * 91) + (g * 13) + 8'h5A);
                    logic [10:0] exp;
                    string       tg;
                    @(negedge clk);
                    ev = '0; wr = 1'b1; wdata = pat;
                    @(negedge clk);
                    ev = 9'(m); mode = 2'(md);
                    en = g[0]; gh = g[1]; gl = g[2];
                    wdata = ~pat;
                    exp = model(9'(m), 2'(md), g[0], g[1], g[2], pat, ~pat);
                    tg = tag_of(9'(m), 2'(md));
                    @(negedge clk);
                    check(tg, "flags", int'(flags), int'(exp[7:0]));
                    check(tg, "restart", int'(rreq), int'(exp[10]));
                    check(tg, "select", int'(sel), int'(exp[9:8]));
                    ev = '0; wr = 1'b0;
                    @(negedge clk);
                    check("R11", "restart end", int'(rreq), 0);
                    check("R11", "idle select", int'(sel), 0);
                    check("R10", "hold", int'(flags), int'(exp[7:0]));
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule